// File: doc/BRIEF.md
# EEPROM Page-Write Commit Controller

This block sits between the serial-bus protocol engine of a 256-byte EEPROM and its storage array. During a write transaction it gathers the incoming data bytes into an eight-byte page buffer. It writes to the array only when the transaction closes with a stop. The protocol engine gives it four strobes: a start strobe that carries the 8-bit word address, a byte strobe with its data, a stop strobe and an abort strobe. The block also reads a write-protect pin and a slow timing tick.

After a stop, the controller walks the eight buffer offsets in ascending order. For each offset that received a byte, and that write protection does not cover, it pulses the array write port. It then holds `busy` for a programmable number of ticks to model the internal write time. The protocol engine withholds its acknowledge while `busy` is high, and the controller ignores every strobe during that time.

The controller is built around four named states:
- `ST_IDLE`: waiting for a transaction.
- `ST_COLLECT`: filling the buffer.
- `ST_COMMIT`: eight cycles, one offset per cycle.
- `ST_SETTLE`: counting ticks.

It has six named transitions:
- start: IDLE→COLLECT, and COLLECT→COLLECT, which reloads the address.
- abort: COLLECT→IDLE.
- empty stop: COLLECT→IDLE.
- stop with data: COLLECT→COMMIT.
- last offset: COMMIT→SETTLE.
- tick count reached: SETTLE→IDLE.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset `busy` and `mem_we` are 0 and the controller waits for a start strobe.
- R2: The word address given with the start strobe splits into a page number (bits 7:3) and a byte offset (bits 2:0). The first data byte goes to that offset of that page.
- R3: Each accepted byte advances only the 3-bit offset, modulo 8. The byte after offset 7 lands at offset 0 of the same page, and the page bits never change.
- R4: When more than eight bytes arrive in one transaction, later bytes replace earlier ones at the same offset. Each offset is written at most once per commit, with the last value received for it.
- R5: Only offsets that received a byte are written. All other array locations keep their contents.
- R6: A stop after at least one byte raises `busy` on the cycle after the stop strobe. The write port then pulses over the next eight cycles, in ascending offset order, with `mem_addr` = {page, offset}.
- R7: `busy` stays high until WRITE_TICKS ticks have been counted after the commit pass, and falls on the cycle after the last of them. Start, byte and stop strobes that arrive while `busy` is high have no effect.
- R8: While `wp` is 1, no write reaches addresses 0x80–0xFF, but addresses 0x00–0x7F are still written. While `wp` is 0, the whole array is writable.
- R9: An abort, or a new start, that arrives before the stop discards the bytes already collected. Nothing from that transaction is written, and an abort leaves `busy` low.
- R10: A stop that arrives with no byte collected writes nothing and does not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | Start-of-write strobe |
| wr_addr | input | 8 | Word address, sampled with `wr_start` |
| byte_valid | input | 1 | Received-byte strobe |
| byte_data | input | 8 | Received byte |
| wr_stop | input | 1 | Stop strobe, requests a commit |
| wr_abort | input | 1 | Abort strobe, discards the transaction |
| wp | input | 1 | Write protect for the upper half of the array |
| tick | input | 1 | Write-cycle timing tick |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 8 | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Internal write cycle in progress |

## Verification
Each strobe is sampled at one rising edge. `busy` is due one cycle after the stop edge. The write pulses fall on the eight edges after that, so a write log is complete nine cycles after the stop. `busy` falls one cycle after the edge that sees the final tick.

The bench drives every strobe for exactly one cycle, starting at a falling edge. It checks `busy` at the first falling edge after the stop. It checks the write log and the bench-side array after nine further cycles. It issues ticks one at a time, and checks that `busy` is still high after WRITE_TICKS−1 ticks and low right after the last one.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 8;
    localparam int OFF_W      = 3;
    localparam int PAGE_BYTES = 1 << OFF_W;
    localparam int PAGE_W     = ADDR_W - OFF_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_COMMIT,
        ST_SETTLE
    } pcc_state_e;
endpackage

// File: rtl/pcc_page_buf.sv
module pcc_page_buf
    import pcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [OFF_W-1:0]  load_off,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);
    logic [OFF_W-1:0]      ptr_q;
    logic [PAGE_BYTES-1:0] mask_q;
    logic [DATA_W-1:0]     slot_q [PAGE_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (clear)
            ptr_q <= load_off;
        else if (wr_en)
            ptr_q <= ptr_q + 1'b1;
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[g] <= 1'b0;
                slot_q[g] <= '0;
            end else if (clear) begin
                mask_q[g] <= 1'b0;
            end else if (wr_en && ptr_q == OFF_W'(g)) begin
                mask_q[g] <= 1'b1;
                slot_q[g] <= wr_data;
            end
        end
    end

    assign rd_data   = slot_q[rd_idx];
    assign rd_valid  = mask_q[rd_idx];
    assign any_valid = |mask_q;

    AST_OFFSET_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && !$past(clear)) |-> ptr_q == OFF_W'($past(ptr_q) + 1'b1)); // R3
endmodule

// File: rtl/pcc_tick_timer.sv
module pcc_tick_timer #(
    parameter int WRITE_TICKS = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CNT_W = $clog2(WRITE_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WRITE_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    assign done = run && tick && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || done)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R7
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
    import pcc_pkg::*;
#(
    parameter int WRITE_TICKS = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic [7:0]        wr_addr,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              wr_stop,
    input  logic              wr_abort,
    input  logic              wp,
    input  logic              tick,
    output logic              mem_we,
    output logic [7:0]        mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              busy
);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

    pcc_state_e          state_q, state_d;
    logic [PAGE_W-1:0]   page_q;
    logic [OFF_W-1:0]    idx_q;
    logic                start_take;
    logic                byte_take;
    logic [DATA_W-1:0]   rd_data;
    logic                rd_valid;
    logic                any_valid;
    logic                settle_done;
    logic                upper_locked;

    assign start_take = wr_start && (state_q == ST_IDLE || state_q == ST_COLLECT);
    assign byte_take  = (state_q == ST_COLLECT) && byte_valid && !wr_start && !wr_abort;

    pcc_page_buf i_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_take),
        .load_off  (wr_addr[OFF_W-1:0]),
        .wr_en     (byte_take),
        .wr_data   (byte_data),
        .rd_idx    (idx_q),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .any_valid (any_valid)
    );

    pcc_tick_timer #(.WRITE_TICKS(WRITE_TICKS)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_SETTLE),
        .tick  (tick),
        .done  (settle_done)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_start) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (wr_abort)      state_d = ST_IDLE;
                else if (wr_start) state_d = ST_COLLECT;
                else if (wr_stop)  state_d = any_valid ? ST_COMMIT : ST_IDLE;
            end
            ST_COMMIT: begin
                if (idx_q == LAST_OFF) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (settle_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            page_q  <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start_take)
                page_q <= wr_addr[ADDR_W-1:OFF_W];
            if (state_q == ST_COMMIT)
                idx_q <= idx_q + 1'b1;
            else
                idx_q <= '0;
        end
    end

    // Outputs
    always_comb begin
        upper_locked = wp && page_q[PAGE_W-1];
        busy         = (state_q == ST_COMMIT) || (state_q == ST_SETTLE);
        mem_we       = (state_q == ST_COMMIT) && rd_valid && !upper_locked;
        mem_addr     = {page_q, idx_q};
        mem_wdata    = rd_data;
    end

    AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R6
    AST_WP_UPPER_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && wp) |-> !mem_addr[7]); // R8
    AST_BUSY_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLLECT && wr_stop && !wr_start && !wr_abort && any_valid) |=> busy); // R6
    AST_ABORT_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLLECT && wr_abort) |=> !busy); // R9
    AST_BUSY_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !busy) |-> ($past(state_q) == ST_SETTLE && $past(tick))); // R7
endmodule

// File: tb/test_page_commit_ctrl.sv
module test_page_commit_ctrl;
    localparam int NT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_start = 1'b0, byte_valid = 1'b0, wr_stop = 1'b0, wr_abort = 1'b0;
    logic       wp = 1'b0, tick = 1'b0;
    logic [7:0] wr_addr = '0, byte_data = '0;
    logic       mem_we, busy;
    logic [7:0] mem_addr, mem_wdata;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    logic [7:0] ram     [256];
    logic [7:0] exp_mem [256];
    logic [7:0] log_addr [16];
    int         log_n = 0;
    logic       log_clr = 1'b0;

    always #5 clk = ~clk;

    page_commit_ctrl #(.WRITE_TICKS(NT)) i_page_commit_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .wr_stop(wr_stop),
        .wr_abort(wr_abort), .wp(wp), .tick(tick), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy)
    );

    // Bench-side synchronous RAM and write log
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        if (log_clr) log_n <= 0;
        else if (mem_we) begin
            if (log_n < 16) log_addr[log_n] <= mem_addr;
            log_n <= log_n + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_mem(input string req);
        int bad = -1;
        for (int a = 0; a < 256; a++)
            if (bad < 0 && ram[a] !== exp_mem[a]) bad = a;
        checks++;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s at %0h actual=%0h expected=%0h", req, bad, ram[bad], exp_mem[bad]);
        end
    endtask

    task automatic pulse_start(input logic [7:0] a);
        @(negedge clk); wr_start = 1'b1; wr_addr = a;
        @(negedge clk); wr_start = 1'b0;
    endtask
    task automatic pulse_byte(input logic [7:0] d);
        @(negedge clk); byte_valid = 1'b1; byte_data = d;
        @(negedge clk); byte_valid = 1'b0;
    endtask
    task automatic pulse_stop();
        @(negedge clk); wr_stop = 1'b1;
        @(negedge clk); wr_stop = 1'b0;
    endtask
    task automatic pulse_abort();
        @(negedge clk); wr_abort = 1'b1;
        @(negedge clk); wr_abort = 1'b0;
    endtask
    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask
    task automatic clear_log();
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
    endtask

    // Collect n bytes from address a, update model, send stop
    task automatic send_txn(input logic [7:0] a, input int n, input logic [7:0] d0);
        pulse_start(a);
        for (int k = 0; k < n; k++) begin
            logic [7:0] ad;
            ad = {a[7:3], 3'(a[2:0] + k)};
            pulse_byte(8'(d0 + k));
            if (!(wp && a[7])) exp_mem[ad] = 8'(d0 + k);
        end
        pulse_stop();
    endtask

    // Runs right after the stop pulse; checks commit pass and settle time
    task automatic finish_cycle(input string req, input logic [7:0] a, input int nwr);
        check({req, " R6 busy after stop"}, busy, 1);
        repeat (9) @(negedge clk);
        check({req, " R6 write count"}, log_n, nwr);
        for (int k = 1; k < nwr && k < 16; k++)
            check({req, " R6 ascending order / R3 same page"},
                  (log_addr[k][2:0] > log_addr[k-1][2:0]) && (log_addr[k][7:3] == a[7:3]), 1);
        for (int k = 0; k < NT - 1; k++) pulse_tick();
        check({req, " R7 busy held"}, busy, 1);
        pulse_tick();
        check({req, " R7 busy falls"}, busy, 0);
        check_mem({req, " R5 array contents"});
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 mem_we", mem_we, 0);
    endtask

    task automatic t_single();
        clear_log();
        send_txn(8'h25, 1, 8'hA1);
        finish_cycle("R2 single", 8'h25, 1);
        check("R2 byte at 25", ram[8'h25], 8'hA1);
    endtask

    task automatic t_wrap();
        clear_log();
        send_txn(8'h46, 3, 8'h10);
        finish_cycle("R3 wrap", 8'h46, 3);
        check("R3 third byte at 40", ram[8'h40], 8'h12);
        check("R3 next page untouched", ram[8'h48], 8'h48 ^ 8'h5A);
    endtask

    task automatic t_overflow();
        clear_log();
        send_txn(8'h10, 10, 8'hB0);
        finish_cycle("R4 overflow", 8'h10, 8);
        check("R4 offset0 replaced", ram[8'h10], 8'hB8);
        check("R4 offset1 replaced", ram[8'h11], 8'hB9);
    endtask

    task automatic t_busy_ignore();
        clear_log();
        send_txn(8'h60, 2, 8'hC0);
        check("R6 busy after stop", busy, 1);
        send_txn(8'h30, 1, 8'hEE);
        exp_mem[8'h30] = ram[8'h30];
        repeat (4) @(negedge clk);
        check("R6 write count", log_n, 2);
        for (int k = 0; k < NT; k++) pulse_tick();
        check("R7 busy falls", busy, 0);
        repeat (3) @(negedge clk);
        check("R7 strobes ignored while busy, no second cycle", busy, 0);
        check("R7 ignored byte not written", ram[8'h30], 8'h30 ^ 8'h5A);
        check_mem("R7 array contents");
    endtask

    task automatic t_protect();
        wp = 1'b1;
        clear_log();
        send_txn(8'h90, 2, 8'h77);
        finish_cycle("R8 upper protected", 8'h90, 0);
        check("R8 upper unchanged", ram[8'h90], 8'h90 ^ 8'h5A);
        clear_log();
        send_txn(8'h08, 1, 8'h3C);
        finish_cycle("R8 lower writable", 8'h08, 1);
        wp = 1'b0;
        clear_log();
        send_txn(8'hF0, 1, 8'h4D);
        finish_cycle("R8 wp low upper writable", 8'hF0, 1);
        check("R8 byte at F0", ram[8'hF0], 8'h4D);
    endtask

    task automatic t_discard();
        clear_log();
        pulse_start(8'h50);
        pulse_byte(8'h01);
        pulse_byte(8'h02);
        pulse_abort();
        check("R9 abort no busy", busy, 0);
        pulse_start(8'h68);
        pulse_byte(8'h03);
        pulse_start(8'h70);
        pulse_byte(8'h04);
        exp_mem[8'h70] = 8'h04;
        pulse_stop();
        finish_cycle("R9 restart", 8'h70, 1);
        check("R9 aborted byte absent", ram[8'h50], 8'h50 ^ 8'h5A);
        check("R9 superseded byte absent", ram[8'h68], 8'h68 ^ 8'h5A);
    endtask

    task automatic t_empty_stop();
        clear_log();
        pulse_start(8'h20);
        pulse_stop();
        check("R10 no busy", busy, 0);
        repeat (9) @(negedge clk);
        check("R10 no writes", log_n, 0);
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int a = 0; a < 256; a++) begin
            ram[a]     = 8'(a) ^ 8'h5A;
            exp_mem[a] = 8'(a) ^ 8'h5A;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_wrap();
        t_overflow();
        t_busy_ignore();
        t_protect();
        t_discard();
        t_empty_stop();
        summary();
    end
endmodule